// File: doc/BRIEF.md
# Three-Slot CAN Transmit Mailbox

This block holds up to three outgoing standard-format CAN frames until a downstream serialiser collects them. A host offers one frame per cycle on a write port. The frame carries an 11-bit identifier, a remote-request flag, a 4-bit length code and eight raw data bytes. The block stores the frame in the free slot with the smallest index. If every slot is occupied, it refuses the frame with a busy response and leaves its state untouched. The write port reports the chosen slot at the same time as the offer.

While a frame is loaded, its slot holds its transmit request low. The request rises one cycle after the load, once the identifier, length and both packed data words are in place. The data bytes are packed little-endian into a low and a high 32-bit word. Bytes at or beyond the length code are zeroed, and a length above eight counts as eight for packing.

Downstream, the block offers the pending slot with the smallest index. A valid/ready transfer marks that slot as in flight. A later done pulse clears the slot's request and marks it empty. Per-slot empty and request flags and an all-empty flag show the state.

Top module: `can_txmbx_top`

## Requirements
- R1: After reset all three slots are empty, no request is pending, `wr_busy` and `tx_valid` are low and `all_empty` is high.
- R2: An accepted write goes to the empty slot with the lowest index; `wr_slot` shows that index (0, 1 or 2) combinationally in the write cycle, and that slot's `slot_empty` bit (bit k is slot k) falls at the next edge.
- R3: A write offered while no slot is empty raises `wr_busy` in the same cycle and changes no slot flag and no stored frame.
- R4: At the edge that loads a slot, its `slot_req` bit is low; the bit rises at the following edge.
- R5: The identifier, remote flag and length code are presented unchanged on `tx_id`, `tx_rtr` and `tx_dlc`; a length code from 9 to 15 is stored as written.
- R6: `tx_data_lo` carries data bytes 0..3 and `tx_data_hi` bytes 4..7, byte n of each word in bits [8n+7:8n]; every byte whose position is at or above min(length code, 8) reads as zero.
- R7: `all_empty` is high exactly when all three `slot_empty` bits are high.
- R8: `tx_valid` is high when some slot has its request set and no frame is in flight; `tx_slot` then names the lowest such slot. A cycle with `tx_valid` and `tx_ready` both high puts that slot in flight: `tx_valid` drops and `tx_slot` and the frame fields hold.
- R9: `tx_done` while a frame is in flight sets that slot's empty bit and clears its request bit at the same edge.
- R10: A write and a done in the same cycle both take effect, on different slots.
- R11: `tx_done` while no frame is in flight has no effect on any flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Host offers a frame this cycle |
| wr_id | input | 11 | Standard identifier |
| wr_rtr | input | 1 | Remote-request flag |
| wr_dlc | input | 4 | Length code |
| wr_data | input | 64 | Data bytes, byte n in bits [8n+7:8n] |
| wr_busy | output | 1 | Offer refused, no empty slot |
| wr_slot | output | 2 | Slot chosen for the offer |
| slot_empty | output | 3 | Per-slot empty flags |
| slot_req | output | 3 | Per-slot transmit request flags |
| all_empty | output | 1 | All slots empty |
| tx_valid | output | 1 | A pending frame is offered |
| tx_ready | input | 1 | Downstream takes the offered frame |
| tx_done | input | 1 | Downstream finished the in-flight frame |
| tx_slot | output | 2 | Slot of the offered or in-flight frame |
| tx_id | output | 11 | Identifier of that frame |
| tx_rtr | output | 1 | Remote flag of that frame |
| tx_dlc | output | 4 | Length code of that frame |
| tx_data_lo | output | 32 | Packed bytes 0..3 |
| tx_data_hi | output | 32 | Packed bytes 4..7 |

## Verification
A host load and a downstream release can fall in the same cycle. In that cycle the block must pick a free slot while a different, occupied slot is being freed. The bench fills two slots, puts the first in flight and then raises `tx_done` together with a new write. It checks that the write lands in the slot freed earlier, that the in-flight slot becomes empty at the same edge, and that in the next cycle the offer moves to the slot that is already pending. The offer moves to the newly loaded slot only once that slot's request rises. A sweep over all sixteen length codes checks byte masking against arithmetic expectations.

// File: rtl/can_txmbx_pkg.sv
package can_txmbx_pkg;
  localparam int unsigned ID_W      = 11;
  localparam int unsigned LEN_W     = 4;
  localparam int unsigned MAX_BYTES = 8;
  localparam int unsigned WORD_W    = 32;
  localparam int unsigned DATA_W    = MAX_BYTES * 8;

  typedef struct packed {
    logic [ID_W-1:0]   id;
    logic              rtr;
    logic [LEN_W-1:0]  len;
    logic [WORD_W-1:0] lo;
    logic [WORD_W-1:0] hi;
  } frame_t;

  // number of bytes that survive packing for a given length code
  function automatic logic [LEN_W-1:0] clamp_len(input logic [LEN_W-1:0] len);
    return (len > LEN_W'(MAX_BYTES)) ? LEN_W'(MAX_BYTES) : len;
  endfunction
endpackage

// File: rtl/can_txmbx_pick.sv
module can_txmbx_pick #(
  parameter int unsigned N = 3,
  localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     cand,
  output logic             found,
  output logic [IDX_W-1:0] idx
);
  // lowest set bit wins
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (cand[k]) begin
        found = 1'b1;
        idx   = IDX_W'(k);
      end
    end
  end
endmodule

// File: rtl/can_txmbx_packer.sv
module can_txmbx_packer
  import can_txmbx_pkg::*;
(
  input  logic [LEN_W-1:0]  len,
  input  logic [DATA_W-1:0] raw,
  output logic [WORD_W-1:0] lo,
  output logic [WORD_W-1:0] hi
);
  logic [LEN_W-1:0]  keep_len;
  logic [DATA_W-1:0] masked;

  assign keep_len = clamp_len(len);

  for (genvar b = 0; b < MAX_BYTES; b++) begin : g_byte
    assign masked[8*b +: 8] = (LEN_W'(b) < keep_len) ? raw[8*b +: 8] : 8'h00;
  end

  assign lo = masked[WORD_W-1:0];
  assign hi = masked[DATA_W-1:WORD_W];
endmodule

// File: rtl/can_txmbx_slot.sv
module can_txmbx_slot
  import can_txmbx_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   load,
  input  frame_t frame_in,
  input  logic   release_slot,
  output logic   empty,
  output logic   req,
  output frame_t frame_q
);
  logic   empty_q, empty_d;
  logic   req_q, req_d;
  logic   arm_q, arm_d;
  logic   frame_en;

  always_comb begin
    empty_d  = empty_q;
    req_d    = req_q;
    arm_d    = arm_q;
    frame_en = 1'b0;
    if (load) begin
      // request held low while the fields are written
      empty_d  = 1'b0;
      req_d    = 1'b0;
      arm_d    = 1'b1;
      frame_en = 1'b1;
    end else if (arm_q) begin
      req_d = 1'b1;
      arm_d = 1'b0;
    end
    if (release_slot) begin
      empty_d = 1'b1;
      req_d   = 1'b0;
      arm_d   = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      empty_q <= 1'b1;
      req_q   <= 1'b0;
      arm_q   <= 1'b0;
    end else begin
      empty_q <= empty_d;
      req_q   <= req_d;
      arm_q   <= arm_d;
    end
  end

  // payload storage, no reset needed
  always_ff @(posedge clk) begin
    if (frame_en) frame_q <= frame_in;
  end

  assign empty = empty_q;
  assign req   = req_q;
endmodule

// File: rtl/can_txmbx_top.sv
module can_txmbx_top
  import can_txmbx_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 3,
  localparam int unsigned IDX_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_valid,
  input  logic [ID_W-1:0]      wr_id,
  input  logic                 wr_rtr,
  input  logic [LEN_W-1:0]     wr_dlc,
  input  logic [DATA_W-1:0]    wr_data,
  output logic                 wr_busy,
  output logic [IDX_W-1:0]     wr_slot,
  output logic [NUM_SLOTS-1:0] slot_empty,
  output logic [NUM_SLOTS-1:0] slot_req,
  output logic                 all_empty,
  output logic                 tx_valid,
  input  logic                 tx_ready,
  input  logic                 tx_done,
  output logic [IDX_W-1:0]     tx_slot,
  output logic [ID_W-1:0]      tx_id,
  output logic                 tx_rtr,
  output logic [LEN_W-1:0]     tx_dlc,
  output logic [WORD_W-1:0]    tx_data_lo,
  output logic [WORD_W-1:0]    tx_data_hi
);
  // asynchronous assert, synchronous release
  logic [1:0] rst_pipe_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  // write side
  logic       free_found;
  logic [IDX_W-1:0] free_idx;
  logic       wr_take;
  frame_t     frame_in;
  logic [WORD_W-1:0] pk_lo, pk_hi;

  can_txmbx_pick #(.N(NUM_SLOTS)) u_free_pick (
    .cand  (slot_empty),
    .found (free_found),
    .idx   (free_idx)
  );

  can_txmbx_packer u_packer (
    .len (wr_dlc),
    .raw (wr_data),
    .lo  (pk_lo),
    .hi  (pk_hi)
  );

  assign frame_in = '{id: wr_id, rtr: wr_rtr, len: wr_dlc, lo: pk_lo, hi: pk_hi};
  assign wr_take  = wr_valid & free_found;
  assign wr_busy  = wr_valid & ~free_found;
  assign wr_slot  = free_idx;

  // downstream side
  logic             pend_found;
  logic [IDX_W-1:0] pend_idx;
  logic             fly_q, fly_d;
  logic [IDX_W-1:0] fly_idx_q, fly_idx_d;
  logic             fly_en;
  logic             tx_take, done_ok;

  can_txmbx_pick #(.N(NUM_SLOTS)) u_pend_pick (
    .cand  (slot_req),
    .found (pend_found),
    .idx   (pend_idx)
  );

  assign tx_valid = pend_found & ~fly_q;
  assign tx_take  = tx_valid & tx_ready;
  assign done_ok  = tx_done & fly_q;

  always_comb begin
    fly_d     = fly_q;
    fly_idx_d = fly_idx_q;
    fly_en    = 1'b0;
    if (tx_take) begin
      fly_d     = 1'b1;
      fly_idx_d = pend_idx;
      fly_en    = 1'b1;
    end else if (done_ok) begin
      fly_d  = 1'b0;
      fly_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      fly_q     <= 1'b0;
      fly_idx_q <= '0;
    end else if (fly_en) begin
      fly_q     <= fly_d;
      fly_idx_q <= fly_idx_d;
    end
  end

  // slot array
  frame_t slot_frame [NUM_SLOTS];

  for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_slot
    logic load_k, rel_k;
    assign load_k = wr_take & (free_idx == IDX_W'(k));
    assign rel_k  = done_ok & (fly_idx_q == IDX_W'(k));

    can_txmbx_slot u_slot (
      .clk          (clk),
      .rst_n        (rst_int_n),
      .load         (load_k),
      .frame_in     (frame_in),
      .release_slot (rel_k),
      .empty        (slot_empty[k]),
      .req          (slot_req[k]),
      .frame_q      (slot_frame[k])
    );
  end

  assign all_empty = &slot_empty;

  frame_t shown;
  assign tx_slot    = fly_q ? fly_idx_q : pend_idx;
  assign shown      = slot_frame[tx_slot];
  assign tx_id      = shown.id;
  assign tx_rtr     = shown.rtr;
  assign tx_dlc     = shown.len;
  assign tx_data_lo = shown.lo;
  assign tx_data_hi = shown.hi;
endmodule

// File: rtl/can_txmbx_checker.sv
module can_txmbx_checker #(
  parameter int unsigned NUM_SLOTS = 3,
  localparam int unsigned IDX_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 wr_valid,
  input logic                 wr_busy,
  input logic [NUM_SLOTS-1:0] slot_empty,
  input logic [NUM_SLOTS-1:0] slot_req,
  input logic                 all_empty,
  input logic                 tx_valid,
  input logic                 tx_ready,
  input logic                 tx_done,
  input logic [IDX_W-1:0]     tx_slot
);
  // R3: a full mailbox refuses the offer
  a_r3_busy_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && slot_empty == '0) |-> wr_busy);

  // R7: nothing is offered while every slot is empty
  a_r7_empty_no_offer: assert property (@(posedge clk) disable iff (!rst_n)
    all_empty |-> !tx_valid);

  // R8: the offered slot has its request set
  a_r8_offer_has_req: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> slot_req[tx_slot]);

  // R8: an accepted offer holds its slot and withdraws valid
  a_r8_hold_in_flight: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> (!tx_valid && $stable(tx_slot)));

  for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_chk
    // R4: request low at the loading edge, set one edge later
    a_r4_req_low_on_load: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(slot_empty[k]) |-> !slot_req[k]);
    a_r4_req_after_load: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(slot_empty[k]) |=> slot_req[k]);
    // R9: a slot only frees on a done pulse
    a_r9_free_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(slot_empty[k]) |-> $past(tx_done));
  end
endmodule

bind can_txmbx_top can_txmbx_checker #(.NUM_SLOTS(NUM_SLOTS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_valid   (wr_valid),
  .wr_busy    (wr_busy),
  .slot_empty (slot_empty),
  .slot_req   (slot_req),
  .all_empty  (all_empty),
  .tx_valid   (tx_valid),
  .tx_ready   (tx_ready),
  .tx_done    (tx_done),
  .tx_slot    (tx_slot)
);

// File: tb/tb_can_txmbx_top.sv
`timescale 1ns/1ps
module tb_can_txmbx_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_valid, wr_rtr, tx_ready, tx_done;
  logic [10:0] wr_id;
  logic [3:0]  wr_dlc;
  logic [63:0] wr_data;
  logic        wr_busy, all_empty, tx_valid, tx_rtr;
  logic [1:0]  wr_slot, tx_slot;
  logic [2:0]  slot_empty, slot_req;
  logic [10:0] tx_id;
  logic [3:0]  tx_dlc;
  logic [31:0] tx_data_lo, tx_data_hi;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  can_txmbx_top dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_id(wr_id), .wr_rtr(wr_rtr),
    .wr_dlc(wr_dlc), .wr_data(wr_data), .wr_busy(wr_busy), .wr_slot(wr_slot),
    .slot_empty(slot_empty), .slot_req(slot_req), .all_empty(all_empty),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_done(tx_done), .tx_slot(tx_slot),
    .tx_id(tx_id), .tx_rtr(tx_rtr), .tx_dlc(tx_dlc),
    .tx_data_lo(tx_data_lo), .tx_data_hi(tx_data_hi)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_eq(input string tag, input logic [63:0] act, input logic [63:0] exp);
    check(act === exp, tag, act, exp);
  endtask

  function automatic logic [63:0] packed_exp(input logic [63:0] d, input int len);
    logic [63:0] r = '0;
    for (int b = 0; b < 8; b++)
      if (b < len) r[8*b +: 8] = d[8*b +: 8];
    return r;
  endfunction

  // called right after a negedge; returns at the next negedge
  task automatic put(input logic [10:0] id, input logic rtr, input logic [3:0] dlc,
                     input logic [63:0] d, input bit exp_busy, input logic [1:0] exp_slot,
                     input bit with_done);
    wr_id = id; wr_rtr = rtr; wr_dlc = dlc; wr_data = d; wr_valid = 1'b1;
    tx_done = with_done;
    #1;
    check_eq("R3 busy", {63'd0, wr_busy}, {63'd0, exp_busy});
    if (!exp_busy) check_eq("R2 slot choice", {62'd0, wr_slot}, {62'd0, exp_slot});
    @(negedge clk);
    wr_valid = 1'b0;
    tx_done = 1'b0;
  endtask

  task automatic pulse_ready();
    tx_ready = 1'b1;
    @(negedge clk);
    tx_ready = 1'b0;
  endtask

  task automatic pulse_done();
    tx_done = 1'b1;
    @(negedge clk);
    tx_done = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [63:0] d;
    rst_n = 1'b0; wr_valid = 1'b0; wr_rtr = 1'b0; wr_id = '0; wr_dlc = '0;
    wr_data = '0; tx_ready = 1'b0; tx_done = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check_eq("R1 empty", {61'd0, slot_empty}, 64'd7);
    check_eq("R1 req", {61'd0, slot_req}, 64'd0);
    check_eq("R1 all_empty", {63'd0, all_empty}, 64'd1);
    check_eq("R1 tx_valid", {63'd0, tx_valid}, 64'd0);
    #1; check_eq("R1 busy", {63'd0, wr_busy}, 64'd0);
    @(negedge clk);

    // R5 R6 sweep over every length code through slot 0
    for (int len = 0; len < 16; len++) begin
      d = 64'h8877_6655_4433_2211 ^ {8{len[7:0]}};
      put(11'(len * 37 + 5), len[0], 4'(len), d, 1'b0, 2'd0, 1'b0);
      check_eq("R4 req low at load", {63'd0, slot_req[0]}, 64'd0);
      check_eq("R2 slot0 taken", {61'd0, slot_empty}, 64'd6);
      @(negedge clk);
      check_eq("R4 req set", {63'd0, slot_req[0]}, 64'd1);
      check_eq("R8 valid", {63'd0, tx_valid}, 64'd1);
      check_eq("R5 id", {53'd0, tx_id}, 64'(len * 37 + 5));
      check_eq("R5 rtr", {63'd0, tx_rtr}, {63'd0, len[0]});
      check_eq("R5 dlc", {60'd0, tx_dlc}, 64'(len));
      check_eq("R6 lo", {32'd0, tx_data_lo}, {32'd0, packed_exp(d, len)[31:0]});
      check_eq("R6 hi", {32'd0, tx_data_hi}, {32'd0, packed_exp(d, len)[63:32]});
      pulse_ready();
      check_eq("R8 valid drops in flight", {63'd0, tx_valid}, 64'd0);
      check_eq("R8 slot held", {62'd0, tx_slot}, 64'd0);
      pulse_done();
      check_eq("R9 freed", {61'd0, slot_empty}, 64'd7);
      check_eq("R9 req cleared", {61'd0, slot_req}, 64'd0);
      check_eq("R7 all_empty back", {63'd0, all_empty}, 64'd1);
    end

    // R2 fill order, R3 busy when full
    put(11'h101, 1'b0, 4'd8, 64'h0102_0304_0506_0708, 1'b0, 2'd0, 1'b0);
    check_eq("R7 not all empty", {63'd0, all_empty}, 64'd0);
    put(11'h202, 1'b1, 4'd2, 64'h1111_2222_3333_4444, 1'b0, 2'd1, 1'b0);
    put(11'h303, 1'b0, 4'd4, 64'hAAAA_BBBB_CCCC_DDDD, 1'b0, 2'd2, 1'b0);
    check_eq("R2 all taken", {61'd0, slot_empty}, 64'd0);
    @(negedge clk);
    put(11'h7FF, 1'b1, 4'd1, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 2'd0, 1'b0);
    check_eq("R3 flags unchanged", {58'd0, slot_empty, slot_req}, {58'd0, 3'b000, 3'b111});
    check_eq("R3 frame unchanged", {53'd0, tx_id}, 64'h101);
    check_eq("R8 lowest pending", {62'd0, tx_slot}, 64'd0);

    // R11 done with nothing in flight
    pulse_done();
    check_eq("R11 ignored", {58'd0, slot_empty, slot_req}, {58'd0, 3'b000, 3'b111});

    pulse_ready();
    pulse_done();
    check_eq("R9 slot0 freed", {61'd0, slot_empty}, 64'd1);
    check_eq("R8 next lowest", {62'd0, tx_slot}, 64'd1);
    check_eq("R8 next id", {53'd0, tx_id}, 64'h202);

    // R10 write and done in the same cycle
    pulse_ready();
    put(11'h0AB, 1'b0, 4'd3, 64'h0000_0000_00C3_B2A1, 1'b0, 2'd0, 1'b1);
    check_eq("R10 both effects", {61'd0, slot_empty}, 64'b010);
    check_eq("R10 req", {61'd0, slot_req}, 64'b100);
    check_eq("R10 offer waits", {62'd0, tx_slot}, 64'd2);
    @(negedge clk);
    check_eq("R10 new frame offered", {62'd0, tx_slot}, 64'd0);
    check_eq("R10 new id", {53'd0, tx_id}, 64'h0AB);
    check_eq("R6 short frame", {32'd0, tx_data_lo}, 64'h00C3_B2A1);

    finished = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule